// File: doc/BRIEF.md
# Clock and Power Mode Sequencer

This block sequences the operating modes of a small microcontroller. Software selects a mode by writing a code to a register. The block turns that mode into four kinds of control output. The first is a processor clock enable. The second is a vector of peripheral clock enables, one bit for each peripheral. The third is a master clock select that picks either the main clock or the 32768 Hz slow clock. The fourth is a signal that switches off the main supply. The block does not contain the gating cells, the oscillators, the PLL or the real-time clock. It only produces the enables and selects and responds to the wake inputs.

There are five modes. In normal mode everything runs from the main clock. Idle mode stops the processor clock until an interrupt request arrives, while the enabled peripheral clocks keep running so that peripheral transfers can continue. Slow mode moves the core and the peripherals onto the slow clock. Standby combines slow mode and idle mode. Power down turns the main supply off. Power down ends on a selected edge of the wake-up pin or on a real-time-clock alarm. Both wake inputs go through a synchronizer before their edges are detected.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode reads 0 (normal). The processor clock enable is 1, every peripheral enable is 0, the main clock is selected, the supply stays on and the wake configuration reads 0.
- R2: Writing address 1 sets each peripheral enable whose data bit is 1. A 0 bit leaves its enable unchanged.
- R3: Writing address 2 clears each peripheral enable whose data bit is 1. A 0 bit leaves its enable unchanged.
- R4: Reading address 3 returns the peripheral enables, with bit i belonging to peripheral i. Reading address 0 returns the current mode code in bits 2:0. The codes are 0 normal, 1 idle, 2 slow, 3 standby and 4 power down.
- R5: In normal or slow mode, writing code 1 to address 0 enters idle. Idle means processor clock enable 0, main clock selected, and peripheral enables still driven. The cycle after an interrupt request is high in idle, the mode is normal.
- R6: Code 2 selects the slow clock with the processor clock running. Code 0 returns to the main clock.
- R7: Code 3 enters standby, which means slow clock selected and processor clock enable 0. The cycle after an interrupt request is high in standby, the mode is slow.
- R8: Code 4 enters power down only when at least one wake source is enabled. In power down the supply-off output is 1, the processor clock enable is 0 and all peripheral enables are 0. With no wake source enabled the request is ignored.
- R9: When the pin source is enabled, power down ends on the selected pin edge. The edge is registered by two synchronizer flops and one edge flop, so the mode is normal on the third rising clock edge after the pin changes. The opposite edge is ignored, and so is any pin edge while the pin source is disabled. After the wake the main clock is selected and the earlier peripheral enables are driven again.
- R10: A rising edge on the alarm input ends power down with the same three-edge latency, but only when alarm wake is enabled. Otherwise the alarm is ignored.
- R11: A mode write is ignored in idle, standby and power down. It is also ignored when the code is 5 to 7 or when the code names the mode already active.
- R12: Address 4 holds the wake configuration and reads back what was written. Bit 0 enables the pin source. Bit 1 selects the falling edge when 1 and the rising edge when 0. Bit 2 enables alarm wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | NUM_PERIPH | Write data |
| rdata | output | NUM_PERIPH | Read data for `addr` (combinational) |
| irq | input | 1 | Interrupt request, synchronous to `clk` |
| wake_pin | input | 1 | External wake-up pin, asynchronous |
| rtc_alarm | input | 1 | Real-time-clock alarm, asynchronous |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| mclk_sel_slow | output | 1 | 1 selects the slow clock as master clock |
| supply_off | output | 1 | 1 switches the main supply off |

## Verification
The bench builds the block with the default eight peripherals and two synchronizer stages. At that size every one of the 256 enable patterns can be set and then partly cleared, with each expected value computed arithmetically. Eight peripherals also keep all three wake-configuration bits in the data path. The bench runs every configuration value against every one of the eight mode codes, starting from both normal and slow mode. That covers every legal transition, every ignored transition, the refused power-down entries, both pin edge polarities, the disabled wake sources and the fixed three-edge wake latency.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power mode sequencer: mode codes, register
// addresses and the layout of the wake configuration field.
package pwr_mode_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_IDLE    = 3'd1,
        MODE_SLOW    = 3'd2,
        MODE_STANDBY = 3'd3,
        MODE_PWRDN   = 3'd4
    } pwr_mode_e;

    localparam logic [ADDR_W-1:0] REG_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_PSET  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_PCLR  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_PSTAT = 3'd3;
    localparam logic [ADDR_W-1:0] REG_WCFG  = 3'd4;

    // bit 2: alarm wake enable, bit 1: falling pin edge, bit 0: pin wake enable
    typedef struct packed {
        logic alarm_en;
        logic pin_fall;
        logic pin_en;
    } wake_cfg_t;

endpackage

// File: rtl/pwr_wake_sync.sv
// Brings an asynchronous wake input into the clock domain through a
// chain of STAGES flops, then pulses for one cycle on the chosen edge.
// Assumes STAGES >= 2 and that want_fall changes only between events.
module pwr_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic want_fall,
    output logic pulse_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              synced;

    assign synced = chain_q[STAGES-1];

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= synced;
    end

    // Pick the requested edge polarity.
    always_comb begin
        if (want_fall) pulse_o = ~synced & last_q;
        else           pulse_o = synced & ~last_q;
    end

    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !want_fall) |=> !(pulse_o && !want_fall));

endmodule

// File: rtl/pwr_periph_gate.sv
// Holds one clock enable bit per peripheral. A set strobe ORs the data
// in and a clear strobe removes the data bits. Assumes the two strobes
// are never active together; if they are, set wins.
module pwr_periph_gate #(
    parameter int NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_we,
    input  logic                  clr_we,
    input  logic [NUM_PERIPH-1:0] bits,
    output logic [NUM_PERIPH-1:0] en_q
);

    // Update the enables from set or clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (set_we) en_q <= en_q | bits;
        else if (clr_we) en_q <= en_q & ~bits;
    end

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(bits)) == $past(bits)));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en_q & $past(bits)) == '0));

    assert_hold_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en_q));

endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode state machine. It takes mode requests from the register
// interface, leaves the sleep modes on interrupt or wake pulses, and
// decodes the current mode into clock and supply controls. Assumes irq
// is already synchronous to clk.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_we,
    input  logic [2:0] mode_code,
    input  wake_cfg_t cfg,
    input  logic      irq,
    input  logic      pin_pulse,
    input  logic      alarm_pulse,
    output pwr_mode_e mode_q,
    output logic      cpu_clk_en,
    output logic      mclk_sel_slow,
    output logic      supply_off,
    output logic      gate_periph
);

    pwr_mode_e mode_nx;
    pwr_mode_e req_mode;
    logic      req_valid;
    logic      pd_allowed;
    logic      req_ok;
    logic      wake;

    assign req_mode   = pwr_mode_e'(mode_code);
    assign req_valid  = (mode_code <= 3'd4);
    assign pd_allowed = cfg.pin_en | cfg.alarm_en;
    assign req_ok     = mode_we && req_valid && (req_mode != mode_q) &&
                        ((req_mode != MODE_PWRDN) || pd_allowed);
    assign wake       = (cfg.pin_en & pin_pulse) | (cfg.alarm_en & alarm_pulse);

    // Choose the next mode from requests and wake events.
    always_comb begin
        mode_nx = mode_q;
        case (mode_q)
            MODE_NORMAL, MODE_SLOW: if (req_ok) mode_nx = req_mode;
            MODE_IDLE:              if (irq)    mode_nx = MODE_NORMAL;
            MODE_STANDBY:           if (irq)    mode_nx = MODE_SLOW;
            MODE_PWRDN:             if (wake)   mode_nx = MODE_NORMAL;
            default:                mode_nx = MODE_NORMAL;
        endcase
    end

    // Register the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_nx;
    end

    // Decode the mode into clock and supply controls.
    always_comb begin
        cpu_clk_en    = 1'b0;
        mclk_sel_slow = 1'b1;
        supply_off    = 1'b0;
        gate_periph   = 1'b0;
        case (mode_q)
            MODE_NORMAL:  begin cpu_clk_en = 1'b1; mclk_sel_slow = 1'b0; end
            MODE_IDLE:    mclk_sel_slow = 1'b0;
            MODE_SLOW:    cpu_clk_en = 1'b1;
            MODE_STANDBY: ;
            MODE_PWRDN:   begin supply_off = 1'b1; gate_periph = 1'b1; end
            default:      ;
        endcase
    end

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && !irq) |=> (mode_q == MODE_IDLE));

    assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && irq) |=> (mode_q == MODE_NORMAL));

    assert_standby_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STANDBY && irq) |=> (mode_q == MODE_SLOW));

    assert_pd_needs_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_PWRDN && !pd_allowed) |=> (mode_q != MODE_PWRDN));

    assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PWRDN && !wake) |=> (mode_q == MODE_PWRDN));

    assert_pd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PWRDN && wake) |=> (mode_q == MODE_NORMAL));

    assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_code > 3'd4) |=> $stable(mode_q));

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top of the power mode sequencer. It decodes register accesses, holds
// the wake configuration, synchronizes the wake inputs and combines the
// mode controls with the peripheral enables. Assumes NUM_PERIPH >= 3 so
// that the mode and configuration fields fit in the data word.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_PERIPH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_PERIPH-1:0] wdata,
    output logic [NUM_PERIPH-1:0] rdata,
    input  logic                  irq,
    input  logic                  wake_pin,
    input  logic                  rtc_alarm,
    output logic                  cpu_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  mclk_sel_slow,
    output logic                  supply_off
);

    localparam int CFG_W = $bits(wake_cfg_t);

    wake_cfg_t             cfg_q;
    pwr_mode_e             mode;
    logic [NUM_PERIPH-1:0] en_q;
    logic                  gate_periph;
    logic                  pin_pulse;
    logic                  alarm_pulse;
    logic                  we_mode, we_set, we_clr, we_cfg;

    assign we_mode = wr_en && (addr == REG_MODE);
    assign we_set  = wr_en && (addr == REG_PSET);
    assign we_clr  = wr_en && (addr == REG_PCLR);
    assign we_cfg  = wr_en && (addr == REG_WCFG);

    // Store the wake configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (we_cfg) cfg_q <= wake_cfg_t'(wdata[CFG_W-1:0]);
    end

    pwr_wake_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (wake_pin),
        .want_fall (cfg_q.pin_fall),
        .pulse_o   (pin_pulse)
    );

    pwr_wake_sync #(.STAGES(SYNC_STAGES)) i_alarm_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (rtc_alarm),
        .want_fall (1'b0),
        .pulse_o   (alarm_pulse)
    );

    pwr_periph_gate #(.NUM_PERIPH(NUM_PERIPH)) i_periph (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (we_set),
        .clr_we (we_clr),
        .bits   (wdata),
        .en_q   (en_q)
    );

    pwr_mode_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_we       (we_mode),
        .mode_code     (wdata[2:0]),
        .cfg           (cfg_q),
        .irq           (irq),
        .pin_pulse     (pin_pulse),
        .alarm_pulse   (alarm_pulse),
        .mode_q        (mode),
        .cpu_clk_en    (cpu_clk_en),
        .mclk_sel_slow (mclk_sel_slow),
        .supply_off    (supply_off),
        .gate_periph   (gate_periph)
    );

    // Drop all peripheral clocks while the supply is off.
    assign periph_clk_en = gate_periph ? '0 : en_q;

    // Return the register selected by addr.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_MODE:  rdata[2:0]       = mode;
            REG_PSTAT: rdata            = en_q;
            REG_WCFG:  rdata[CFG_W-1:0] = cfg_q;
            default:   rdata            = '0;
        endcase
    end

    assert_supply_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_off |-> (!cpu_clk_en && periph_clk_en == '0 && mclk_sel_slow));

    assert_supply_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_off) |-> ($past(cfg_q.pin_en) || $past(cfg_q.alarm_en)));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq = 1'b0;
    logic       wake_pin = 1'b0;
    logic       rtc_alarm = 1'b0;
    logic       cpu_clk_en;
    logic [7:0] periph_clk_en;
    logic       mclk_sel_slow;
    logic       supply_off;

    int checks = 0;
    int fails  = 0;
    int cur    = 0;
    int stat   = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.NUM_PERIPH(8), .SYNC_STAGES(2)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .wake_pin(wake_pin), .rtc_alarm(rtc_alarm),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .mclk_sel_slow(mclk_sel_slow), .supply_off(supply_off)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    function automatic int next_mode(input int m, input int code, input int c);
        if (m != 0 && m != 2) return m;
        if (code > 4) return m;
        if (code == 4 && (c & 5) == 0) return m;
        return code;
    endfunction

    // Compare the mode readback and every output against the mode.
    task automatic chk_mode(input string tag, input int m);
        int v;
        rd(3'd0, v);
        chk({tag, " mode"}, v, m);
        chk({tag, " cpu_clk_en"}, int'(cpu_clk_en), (m == 0 || m == 2) ? 1 : 0);
        chk({tag, " mclk_sel_slow"}, int'(mclk_sel_slow), (m >= 2) ? 1 : 0);
        chk({tag, " supply_off"}, int'(supply_off), (m == 4) ? 1 : 0);
        chk({tag, " periph_clk_en"}, int'(periph_clk_en), (m == 4) ? 0 : stat);
    endtask

    // Leave power down through the enabled source, probing ignored events.
    task automatic wake_up(input int c);
        logic fall;
        fall = c[1];
        if (c[0]) begin
            if (!c[2]) begin
                rtc_alarm = 1'b1; cyc(4); rtc_alarm = 1'b0; cyc(4);
                chk_mode("R10 alarm disabled", 4);
            end
            wake_pin = fall; cyc(4);
            chk_mode("R9 opposite edge", 4);
            wake_pin = ~fall; cyc(2);
            chk_mode("R9 before latency", 4);
            cyc(1);
            chk_mode("R9 pin wake", 0);
        end else begin
            wake_pin = fall; cyc(4); wake_pin = ~fall; cyc(4);
            chk_mode("R9 pin disabled", 4);
            rtc_alarm = 1'b1; cyc(2);
            chk_mode("R10 before latency", 4);
            cyc(1);
            chk_mode("R10 alarm wake", 0);
            rtc_alarm = 1'b0; cyc(4);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_mode("R1 reset", 0);
        rd(3'd3, v); chk("R1 enables", v, 0);
        rd(3'd4, v); chk("R1 wake cfg", v, 0);

        // R2, R3, R4 sweep over all enable patterns
        for (int p = 0; p < 256; p++) begin
            int q;
            q = (p * 37 + 11) & 8'hFF;
            wr(3'd2, 8'hFF);
            wr(3'd1, 8'(p));
            stat = p;
            rd(3'd3, v); chk("R4 status after set", v, p);
            chk("R2 set drives outputs", int'(periph_clk_en), p);
            wr(3'd1, 8'h00);
            rd(3'd3, v); chk("R2 zero set no effect", v, p);
            wr(3'd2, 8'(q));
            stat = p & ~q & 8'hFF;
            rd(3'd3, v); chk("R3 clear", v, stat);
            wr(3'd2, 8'h00);
            chk("R3 zero clear no effect", int'(periph_clk_en), stat);
            wr(3'd1, 8'(q));
            stat = stat | q;
            chk("R2 set merge", int'(periph_clk_en), stat);
        end
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'hA5);
        stat = 8'hA5;

        // R5..R11 sweep of every config, origin and code
        for (int c = 0; c < 8; c++) begin
            wr(3'd4, 8'(c));
            rd(3'd4, v); chk("R12 cfg readback", v, c);
            wake_pin = ~c[1];
            cyc(4);
            for (int o = 0; o < 2; o++) begin
                for (int k = 0; k < 8; k++) begin
                    int e;
                    cur = 0;
                    if (o == 1) begin
                        wr(3'd0, 8'd2); cur = 2;
                        chk_mode("R6 enter slow", 2);
                    end
                    wr(3'd0, 8'(k));
                    e = next_mode(cur, k, c);
                    chk_mode("R11 mode request", e);
                    cur = e;
                    if (e == 1 || e == 3) begin
                        wr(3'd0, 8'd0);
                        chk_mode("R11 write while asleep", e);
                        cyc(3);
                        chk_mode("R5 R7 wait for irq", e);
                        irq = 1'b1; cyc(1); irq = 1'b0;
                        cur = (e == 1) ? 0 : 2;
                        chk_mode(e == 1 ? "R5 idle exit" : "R7 standby exit", cur);
                    end else if (e == 4) begin
                        wr(3'd0, 8'd2);
                        chk_mode("R11 write while off", 4);
                        irq = 1'b1; cyc(1); irq = 1'b0;
                        chk_mode("R8 irq ignored", 4);
                        wake_up(c);
                        cur = 0;
                    end
                    if (cur != 0) begin
                        wr(3'd0, 8'd0);
                        chk_mode("R6 back to main", 0);
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule